// File: doc/BRIEF.md
# Processor Ready and Wait-for-Interrupt Controller

This block decides, cycle by cycle, whether a processor core may advance. An external ready input is sampled on each rising clock edge. When it is sampled low, the block drops the core's cycle-enable for the following cycle and raises a hold signal. The hold signal keeps the address bus and the read/write line steady for as long as the stall lasts. The stall does not depend on the kind of bus cycle in progress. Reads, writes and internal cycles all stop alike, so slow memory, a DMA agent or a single-step circuit can freeze the core at any point.

The block also provides the wait-for-interrupt state. When the core reports that it has executed a wait instruction while advancing, an active-low wait indicator goes low on the next edge. A pending enabled IRQ or a pending NMI sends it high again on the edge after the request is seen. The wait indicator does not stall the core by itself. It takes effect only when the system feeds it back into the ready input, for example through a wired-AND. Without that loop, execution carries on as if no wait instruction had run.

The reset input is asserted asynchronously and released through a synchronizer. While reset is active, the ready input is ignored.

Top module: `ready_wait_ctrl`

## Requirements
- R1: While rst_n is low, and until RST_STAGES rising edges have passed with rst_n high, cyc_en_o is 1, wait_n_o is 1 and bus_hold_o is 0, whatever rdy_i carries.
- R2: Once out of reset, rdy_i sampled low at a rising edge makes cyc_en_o 0 from that edge until the next one.
- R3: cyc_en_o stays 0 for as long as rdy_i is sampled low at each edge, and returns to 1 right after the first edge that samples rdy_i high.
- R4: bus_hold_o is 1 exactly in the cycles where cyc_en_o is 0, for every cycle type.
- R5: If wai_i is high at an edge where cyc_en_o is 1 and neither irq_pend_i nor nmi_pend_i is high, wait_n_o is 0 after that edge.
- R6: Once wait_n_o is 0, it stays 0 until irq_pend_i or nmi_pend_i is sampled high, and is 1 right after that edge, whether or not the core is stalled.
- R7: wai_i sampled at an edge where cyc_en_o is 0 has no effect: wait_n_o stays 1.
- R8: If wai_i arrives in the same cycle as irq_pend_i or nmi_pend_i, the wait state is not entered, and wait_n_o stays 1.
- R9: cyc_en_o follows only rdy_i. With wait_n_o not fed back, a wait instruction leaves the core advancing.
- R10: When wait_n_o is ANDed into rdy_i, the core stays stalled from the edge after the wait instruction until the edge after the interrupt request, and then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rdy_i | input | 1 | External ready; low stalls the core |
| wai_i | input | 1 | Strobe from the core: a wait instruction is executing |
| irq_pend_i | input | 1 | An enabled maskable interrupt is pending |
| nmi_pend_i | input | 1 | A non-maskable interrupt is pending |
| cyc_en_o | output | 1 | Core advance enable for the current cycle |
| wait_n_o | output | 1 | Active-low wait-for-interrupt indicator |
| bus_hold_o | output | 1 | Freezes the address and read/write outputs |

## Verification
Two things can land on the same edge: a wait-instruction strobe and an interrupt request. Another pairing is an interrupt request that arrives while the ready line, fed from the wait output itself, is holding the core stalled. Directed cases place the strobe and each kind of request in one cycle, and place a request in a stalled cycle. A seeded random phase then toggles ready, the strobe and both requests together, both with and without the feedback loop. After every edge, all three outputs are compared with a reference model in the bench that is built from the requirements.

// File: rtl/ready_wait_pkg.sv
package ready_wait_pkg;
  typedef enum logic [0:0] {
    WS_RUN  = 1'b0,
    WS_WAIT = 1'b1
  } wait_state_t;
endpackage

// File: rtl/rwc_reset_sync.sv
module rwc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign run_o = chain_q[LAST];
endmodule

// File: rtl/rwc_ready_sampler.sv
module rwc_ready_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rdy_i,
  output logic cyc_en_o,
  output logic bus_hold_o
);
  logic rdy_q;
  logic rdy_d;

  // Outside the run window the ready line is ignored and the core advances.
  always_comb begin
    rdy_d = 1'b1;
    if (run_i) rdy_d = rdy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b1;
    else        rdy_q <= rdy_d;
  end

  assign cyc_en_o   = rdy_q;
  assign bus_hold_o = ~rdy_q;
endmodule

// File: rtl/rwc_wait_fsm.sv
module rwc_wait_fsm
  import ready_wait_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic cyc_en_i,
  input  logic wai_i,
  input  logic wake_i,
  output logic wait_n_o
);
  wait_state_t state_q;
  wait_state_t state_d;
  logic        enter_en;

  // The strobe only counts when the core is actually advancing.
  assign enter_en = cyc_en_i & wai_i & ~wake_i;

  always_comb begin
    state_d = state_q;
    if (!run_i) begin
      state_d = WS_RUN;
    end else begin
      unique case (state_q)
        WS_RUN:  if (enter_en) state_d = WS_WAIT;
        WS_WAIT: if (wake_i)   state_d = WS_RUN;
        default: state_d = WS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_RUN;
    else        state_q <= state_d;
  end

  assign wait_n_o = (state_q == WS_RUN);
endmodule

// File: rtl/ready_wait_ctrl.sv
module ready_wait_ctrl #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_i,
  input  logic wai_i,
  input  logic irq_pend_i,
  input  logic nmi_pend_i,
  output logic cyc_en_o,
  output logic wait_n_o,
  output logic bus_hold_o
);
  logic run;
  logic wake;

  assign wake = irq_pend_i | nmi_pend_i;

  rwc_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_o (run)
  );

  rwc_ready_sampler u_rdy (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .rdy_i      (rdy_i),
    .cyc_en_o   (cyc_en_o),
    .bus_hold_o (bus_hold_o)
  );

  rwc_wait_fsm u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .cyc_en_i (cyc_en_o),
    .wai_i    (wai_i),
    .wake_i   (wake),
    .wait_n_o (wait_n_o)
  );
endmodule

// File: rtl/ready_wait_ctrl_chk.sv
module ready_wait_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic rdy_i,
  input logic wai_i,
  input logic irq_pend_i,
  input logic nmi_pend_i,
  input logic cyc_en_o,
  input logic wait_n_o,
  input logic bus_hold_o
);
  AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n) !run |-> (cyc_en_o && wait_n_o && !bus_hold_o)); // R1
  AST_STALL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) (run && !rdy_i) |=> !cyc_en_o); // R2
  AST_RESUME_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (run && rdy_i) |=> cyc_en_o); // R3
  AST_HOLD_DURING_STALL: assert property (@(posedge clk) disable iff (!rst_n) !cyc_en_o |-> bus_hold_o); // R4
  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (run && cyc_en_o && wai_i && !irq_pend_i && !nmi_pend_i) |=> !wait_n_o); // R5
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (!wait_n_o && (irq_pend_i || nmi_pend_i)) |=> wait_n_o); // R6
  AST_STALLED_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (wait_n_o && !cyc_en_o) |=> wait_n_o); // R7
  AST_SAME_CYCLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (wait_n_o && (irq_pend_i || nmi_pend_i)) |=> wait_n_o); // R8
endmodule

bind ready_wait_ctrl ready_wait_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .rdy_i      (rdy_i),
  .wai_i      (wai_i),
  .irq_pend_i (irq_pend_i),
  .nmi_pend_i (nmi_pend_i),
  .cyc_en_o   (cyc_en_o),
  .wait_n_o   (wait_n_o),
  .bus_hold_o (bus_hold_o)
);

// File: tb/ready_wait_ctrl_bench.sv
module ready_wait_ctrl_bench;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy_i = 1'b1;
  logic wai_i = 1'b0;
  logic irq_pend_i = 1'b0;
  logic nmi_pend_i = 1'b0;
  logic cyc_en_o, wait_n_o, bus_hold_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int   m_cnt  = 0;
  logic m_run  = 1'b0;
  logic m_rdy  = 1'b1;
  logic m_wait = 1'b0;

  always #5 clk = ~clk;

  ready_wait_ctrl #(.RST_STAGES(STAGES)) u_ready_wait_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_i      (rdy_i),
    .wai_i      (wai_i),
    .irq_pend_i (irq_pend_i),
    .nmi_pend_i (nmi_pend_i),
    .cyc_en_o   (cyc_en_o),
    .wait_n_o   (wait_n_o),
    .bus_hold_o (bus_hold_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic next_wait(input logic run, input logic w_now, input logic cyc,
                                     input logic w, input logic i, input logic n);
    if (!run) return 1'b0;
    if (w_now) return !(i | n);
    return cyc & w & !(i | n);
  endfunction

  // Drive one cycle's inputs just after a falling edge, step the model at the rising edge,
  // then compare at the next falling edge.
  task automatic cycle(input logic r, input logic w, input logic i, input logic n,
                       input logic loopback, input string t_en, input string t_wait);
    logic rdy_eff;
    logic nr, nw;
    rdy_eff    = loopback ? (r & wait_n_o) : r;
    rdy_i      = rdy_eff;
    wai_i      = w;
    irq_pend_i = i;
    nmi_pend_i = n;
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_run = 1'b0; m_rdy = 1'b1; m_wait = 1'b0;
    end else begin
      nr = m_run ? rdy_eff : 1'b1;
      nw = next_wait(m_run, m_wait, m_rdy, w, i, n);
      m_rdy = nr;
      m_wait = nw;
      if (m_cnt < STAGES) m_cnt++;
      m_run = (m_cnt >= STAGES);
    end
    @(negedge clk);
    chk(t_en, "cyc_en_o", cyc_en_o, m_rdy);
    chk("R4", "bus_hold_o", bus_hold_o, !m_rdy);
    chk(t_wait, "wait_n_o", wait_n_o, !m_wait);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R1: held in reset with ready low and a strobe present
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1", "R1");
    rst_n = 1'b1;
    for (int k = 0; k < STAGES; k++) cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1", "R1");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2", "R1");
    // R2 / R3: multi-cycle stall then resume
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2", "R7");
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3", "R7");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3", "R7");
    // R7: strobe during a stall is dropped
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2", "R7");
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3", "R7");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3", "R7");
    // R5 / R9: wait entered without loopback, core keeps advancing
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9", "R5");
    for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9", "R6");
    // R6: IRQ releases
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9", "R6");
    // R8: strobe with IRQ, then strobe with NMI
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3", "R8");
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3", "R8");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3", "R8");
    // R10: loopback stalls until NMI, wake while stalled
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10", "R5");
    for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10", "R6");
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R10", "R6");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10", "R6");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10", "R6");
    // random phase, alternating loopback
    for (int k = 0; k < 4000; k++) begin
      logic lb;
      lb = (k / 500) % 2 == 1;
      cycle(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 9) == 0,
            ($urandom % 13) == 0, lb, lb ? "R10" : "R3", "R6");
    end
    // R1 again: asynchronous reset mid-run
    rst_n = 1'b0;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1", "R1");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule